// File: doc/BRIEF.md
# Burst Memory Cycle Decoder with Sleep Sequencing

This block sits at the control edge of a synchronous, pipelined burst memory. On every rising clock edge it looks at three chip enables, the two address strobes (one for a processor, one for a cache controller), the burst advance, write and output-enable inputs. It sorts the cycle into one of a small set of operations: deselect, start of a read burst, start of a write burst, continuation of a burst, a suspended burst, or snooze. The decode reaches the downstream pipeline one clock later, as a registered operation code. Alongside it come an address-source select (external, next-in-burst, hold, or none) and two data-bus controls: drive read data, or capture write data.

An asynchronous sleep request first passes through a synchronizer. It then drives a four-state sequencer (awake, entering, asleep, exiting). Going into sleep takes a fixed number of cycles, and so does coming out of it. Any burst that is open when entry begins is abandoned and reported. Every cycle outside the awake state is decoded as snooze and ignores its inputs. A strobe seen during the exit (recovery) window raises a protocol-violation pulse.

Top module: `burst_cycle_decoder`

## Requirements
- R1: While `rstN` is low and after its release with idle inputs, `opType` is 0 (deselect), `addrSel` is 3 (none), `dataDrive`, `dataCapture`, `burstAbort` and `protocolViolation` are 0, and `sleepState` is 0 (awake).
- R2: The chip counts as selected only for `ce1N`=0, `ce2`=1, `ce3N`=0. A controller strobe (`adscN`=0) with `ce1N`=1 decodes as deselect (`opType` 0, `addrSel` 3). So does a processor strobe (`adspN`=0, `ce1N`=0) with `ce2`=0 or `ce3N`=1. A deselect closes any open burst.
- R3: `adspN`=0 with the chip selected gives `opType` 1 (read begin) with `addrSel` 0 (external). This holds for either value of `writeN`.
- R4: `adspN`=1, `adscN`=0 and the chip selected gives `opType` 2 (write begin) when `writeN`=0 and `opType` 1 when `writeN`=1. Both use `addrSel` 0.
- R5: A processor strobe with `ce1N`=1 is ignored, and the cycle decodes as if both strobes were high.
- R6: Both strobes high with `advN`=0 continues the open burst. The result is `opType` 3 after a read begin or 4 after a write begin, with `addrSel` 1 (next). With no open burst the cycle is a deselect.
- R7: Both strobes high with `advN`=1 suspends the open burst. The result is `opType` 5 (read hold) or 6 (write hold), with `addrSel` 2 (hold). With no open burst the cycle is a deselect.
- R8: `dataDrive` is 1 only for read codes (1, 3, 5) decoded with `oeN`=0. `dataCapture` is 1 exactly for write codes (2, 4, 6). Both are 0 for every other code.
- R9: All decode outputs are registered. They show the inputs sampled at the previous rising edge and do not follow input changes between edges.
- R10: Let `sleepReq` first be high at edge k. Then `sleepState` becomes 1 (entering) after edge k+2 and 2 (asleep) after edge k+4. `opType` is 7 (snooze), with `addrSel` 3 and no data-bus activity, from edge k+2 until one edge after the state returns to 0. Strobes in that span have no effect.
- R11: If a burst is open when entry begins, `burstAbort` pulses high for exactly the one cycle after edge k+2. The burst is closed, so a continue cycle after wake-up decodes as deselect.
- R12: Let `sleepReq` first be low at edge j. Then `sleepState` becomes 3 (exiting) after edge j+2 and 0 after edge j+4. Either strobe low at an edge while exiting sets `protocolViolation` high for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| writeN | input | 1 | Write select, active low |
| oeN | input | 1 | Output enable, active low |
| sleepReq | input | 1 | Asynchronous sleep request, active high |
| opType | output | 3 | Registered operation code (see R2 to R10) |
| addrSel | output | 2 | Address source: 0 external, 1 next, 2 hold, 3 none |
| dataDrive | output | 1 | Data bus driven with read data |
| dataCapture | output | 1 | Data bus sampled as write data |
| burstAbort | output | 1 | One-cycle pulse: open burst abandoned by sleep entry |
| protocolViolation | output | 1 | One-cycle pulse: strobe during exit recovery |
| sleepState | output | 2 | 0 awake, 1 entering, 2 asleep, 3 exiting |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and two-cycle entry and exit windows. With these values the edge-exact arrival times in R10 and R12 can be predicted and checked cycle by cycle. Short directed sequences cover every decode row, including the processor strobe ignored under `ce1N`=1. They also drive a burst into a sleep request so that the abort pulse is raised, and place a strobe inside the two-cycle recovery window.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [2:0] {
    OP_DESEL    = 3'd0,
    OP_RD_BEGIN = 3'd1,
    OP_WR_BEGIN = 3'd2,
    OP_RD_CONT  = 3'd3,
    OP_WR_CONT  = 3'd4,
    OP_RD_HOLD  = 3'd5,
    OP_WR_HOLD  = 3'd6,
    OP_SNOOZE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SEL_EXT  = 2'd0,
    SEL_NEXT = 2'd1,
    SEL_HOLD = 2'd2,
    SEL_NONE = 2'd3
  } addr_sel_e;

  typedef enum logic [1:0] {
    ST_AWAKE    = 2'd0,
    ST_ENTERING = 2'd1,
    ST_ASLEEP   = 2'd2,
    ST_EXITING  = 2'd3
  } sleep_st_e;

  // Strobes from the sleep control to the decode datapath
  typedef struct packed {
    logic gate;   // cycle is not a normal access: decode as snooze
    logic enter;  // sleep entry starts at this edge
  } sleep_strobe_t;

  function automatic logic isReadOp(op_e op);
    return (op == OP_RD_BEGIN) || (op == OP_RD_CONT) || (op == OP_RD_HOLD);
  endfunction

  function automatic logic isWriteOp(op_e op);
    return (op == OP_WR_BEGIN) || (op == OP_WR_CONT) || (op == OP_WR_HOLD);
  endfunction

endpackage

// File: rtl/bcd_sleep_ctrl.sv
module bcd_sleep_ctrl
  import bcd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sleepReq,
  input  logic          adspN,
  input  logic          adscN,
  output sleep_strobe_t strobe,
  output sleep_st_e     state,
  output logic          violation
);

  localparam int MAX_WIN = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   sleepSync;
  logic [CNT_W-1:0]       winCnt;
  sleep_st_e              stateNext;
  logic [CNT_W-1:0]       winCntNext;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= sleepReq;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sleepReq};
      end
    end
  endgenerate

  assign sleepSync = syncChain[SYNC_STAGES-1];

  always_comb begin
    stateNext  = state;
    winCntNext = winCnt;
    unique case (state)
      ST_AWAKE: begin
        if (sleepSync) begin
          stateNext  = ST_ENTERING;
          winCntNext = '0;
        end
      end
      ST_ENTERING: begin
        if (winCnt == ENTRY_LAST) stateNext = ST_ASLEEP;
        else                      winCntNext = winCnt + 1'b1;
      end
      ST_ASLEEP: begin
        if (!sleepSync) begin
          stateNext  = ST_EXITING;
          winCntNext = '0;
        end
      end
      ST_EXITING: begin
        if (winCnt == EXIT_LAST) stateNext = ST_AWAKE;
        else                     winCntNext = winCnt + 1'b1;
      end
      default: stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_AWAKE;
      winCnt    <= '0;
      violation <= 1'b0;
    end else begin
      state     <= stateNext;
      winCnt    <= winCntNext;
      violation <= (state == ST_EXITING) && (!adspN || !adscN);
    end
  end

  assign strobe.enter = (state == ST_AWAKE) && sleepSync;
  assign strobe.gate  = (state != ST_AWAKE) || strobe.enter;

endmodule

// File: rtl/bcd_cycle_path.sv
module bcd_cycle_path
  import bcd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  sleep_strobe_t strobe,
  input  logic          ce1N,
  input  logic          ce2,
  input  logic          ce3N,
  input  logic          adspN,
  input  logic          adscN,
  input  logic          advN,
  input  logic          writeN,
  input  logic          oeN,
  output op_e           opReg,
  output addr_sel_e     selReg,
  output logic          driveReg,
  output logic          captureReg,
  output logic          abortReg
);

  logic      selected;
  logic      procStrobe;
  logic      burstOpen;
  logic      burstWrite;
  op_e       opNext;
  addr_sel_e selNext;
  logic      openNext;
  logic      writeNext;

  assign selected   = !ce1N && ce2 && !ce3N;
  // processor strobe only counts when the first enable is asserted
  assign procStrobe = !adspN && !ce1N;

  always_comb begin
    opNext    = OP_DESEL;
    selNext   = SEL_NONE;
    openNext  = burstOpen;
    writeNext = burstWrite;
    if (strobe.gate) begin
      opNext = OP_SNOOZE;
      if (strobe.enter) openNext = 1'b0;
    end else if (procStrobe) begin
      if (selected) begin
        opNext    = OP_RD_BEGIN;
        selNext   = SEL_EXT;
        openNext  = 1'b1;
        writeNext = 1'b0;
      end else begin
        openNext = 1'b0;
      end
    end else if (!adscN) begin
      if (selected) begin
        opNext    = writeN ? OP_RD_BEGIN : OP_WR_BEGIN;
        selNext   = SEL_EXT;
        openNext  = 1'b1;
        writeNext = !writeN;
      end else begin
        openNext = 1'b0;
      end
    end else if (burstOpen) begin
      if (!advN) begin
        opNext  = burstWrite ? OP_WR_CONT : OP_RD_CONT;
        selNext = SEL_NEXT;
      end else begin
        opNext  = burstWrite ? OP_WR_HOLD : OP_RD_HOLD;
        selNext = SEL_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg      <= OP_DESEL;
      selReg     <= SEL_NONE;
      driveReg   <= 1'b0;
      captureReg <= 1'b0;
      abortReg   <= 1'b0;
      burstOpen  <= 1'b0;
      burstWrite <= 1'b0;
    end else begin
      opReg      <= opNext;
      selReg     <= selNext;
      driveReg   <= isReadOp(opNext) && !oeN;
      captureReg <= isWriteOp(opNext);
      abortReg   <= strobe.enter && burstOpen;
      burstOpen  <= openNext;
      burstWrite <= writeNext;
    end
  end

endmodule

// File: rtl/burst_cycle_decoder.sv
module burst_cycle_decoder
  import bcd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ce1N,
  input  logic       ce2,
  input  logic       ce3N,
  input  logic       adspN,
  input  logic       adscN,
  input  logic       advN,
  input  logic       writeN,
  input  logic       oeN,
  input  logic       sleepReq,
  output logic [2:0] opType,
  output logic [1:0] addrSel,
  output logic       dataDrive,
  output logic       dataCapture,
  output logic       burstAbort,
  output logic       protocolViolation,
  output logic [1:0] sleepState
);

  sleep_strobe_t sleepStrobe;
  sleep_st_e     stateW;
  op_e           opW;
  addr_sel_e     selW;

  bcd_sleep_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .ENTRY_CYCLES(ENTRY_CYCLES),
    .EXIT_CYCLES (EXIT_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .adspN    (adspN),
    .adscN    (adscN),
    .strobe   (sleepStrobe),
    .state    (stateW),
    .violation(protocolViolation)
  );

  bcd_cycle_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (sleepStrobe),
    .ce1N      (ce1N),
    .ce2       (ce2),
    .ce3N      (ce3N),
    .adspN     (adspN),
    .adscN     (adscN),
    .advN      (advN),
    .writeN    (writeN),
    .oeN       (oeN),
    .opReg     (opW),
    .selReg    (selW),
    .driveReg  (dataDrive),
    .captureReg(dataCapture),
    .abortReg  (burstAbort)
  );

  assign opType     = opW;
  assign addrSel    = selW;
  assign sleepState = stateW;

endmodule

// File: rtl/bcd_checker.sv
module bcd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ce1N,
  input logic       ce2,
  input logic       ce3N,
  input logic       adspN,
  input logic       adscN,
  input logic       advN,
  input logic       writeN,
  input logic       oeN,
  input logic       sleepReq,
  input logic [2:0] opType,
  input logic [1:0] addrSel,
  input logic       dataDrive,
  input logic       dataCapture,
  input logic       burstAbort,
  input logic       protocolViolation,
  input logic [1:0] sleepState
);

  // R2
  desel_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opType == 3'd0) |-> (addrSel == 2'd3 && !dataDrive && !dataCapture));

  // R3
  proc_read_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState == 2'd0 && !adspN && !ce1N && ce2 && !ce3N)
      |=> (sleepState != 2'd0 || (opType == 3'd1 && addrSel == 2'd0)));

  // R8
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataDrive && dataCapture));

  // R8
  drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> (opType == 3'd1 || opType == 3'd3 || opType == 3'd5));

  // R10
  snooze_while_sleeping_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState != 2'd0) |=> (opType == 3'd7 && addrSel == 2'd3));

  // R10
  asleep_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState == 2'd2) |=> (sleepState == 2'd2 || sleepState == 2'd3));

  // R11
  abort_at_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstAbort |-> (sleepState == 2'd1 && opType == 3'd7));

  // R12
  recovery_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState == 2'd3 && (!adspN || !adscN)) |=> protocolViolation);

endmodule

bind burst_cycle_decoder bcd_checker u_bcdChk (.*);

// File: tb/sim_burst_cycle_decoder.sv
`timescale 1ns/1ps
module sim_burst_cycle_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1, writeN = 1'b1, oeN = 1'b1;
  logic sleepReq = 1'b0;
  logic [2:0] opType;
  logic [1:0] addrSel;
  logic dataDrive, dataCapture, burstAbort, protocolViolation;
  logic [1:0] sleepState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_cycle_decoder u0 (.*);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic c1, logic c2, logic c3, logic sp, logic sc,
                       logic av, logic wr, logic oe);
    ce1N = c1; ce2 = c2; ce3N = c3; adspN = sp; adscN = sc;
    advN = av; writeN = wr; oeN = oe;
  endtask

  task automatic expectOp(string req, int op, int sel);
    chk({req, " opType"}, opType, op);
    chk({req, " addrSel"}, addrSel, sel);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) step();
    chk("R1 opType in reset", opType, 0);
    chk("R1 addrSel in reset", addrSel, 3);
    rstN = 1'b1;
    drive(1, 0, 1, 1, 1, 1, 1, 1);
    step();
    expectOp("R1 after release", 0, 3);
    chk("R1 dataDrive", dataDrive, 0);
    chk("R1 dataCapture", dataCapture, 0);
    chk("R1 burstAbort", burstAbort, 0);
    chk("R1 protocolViolation", protocolViolation, 0);
    chk("R1 sleepState", sleepState, 0);
  endtask

  task automatic tDecode();
    drive(1, 1, 0, 1, 0, 1, 1, 1); step(); expectOp("R2 ctrl strobe ce1N high", 0, 3);
    drive(0, 0, 0, 0, 1, 1, 1, 1); step(); expectOp("R2 proc strobe ce2 low", 0, 3);
    drive(0, 1, 1, 0, 1, 1, 1, 1); step(); expectOp("R2 proc strobe ce3N high", 0, 3);
    drive(0, 1, 0, 0, 1, 1, 0, 1);
    chk("R9 no change before edge", opType, 0);
    step(); expectOp("R3 proc strobe writeN low", 1, 0);
    drive(0, 1, 0, 0, 1, 1, 1, 1); step(); expectOp("R3 proc strobe writeN high", 1, 0);
    drive(0, 1, 0, 1, 0, 1, 0, 1); step(); expectOp("R4 ctrl strobe write", 2, 0);
    drive(0, 1, 0, 1, 0, 1, 1, 1); step(); expectOp("R4 ctrl strobe read", 1, 0);
    drive(0, 1, 0, 1, 0, 1, 0, 1); step();
    drive(1, 1, 0, 0, 1, 0, 1, 1); step(); expectOp("R5 proc strobe ignored", 4, 1);
  endtask

  task automatic tBurst();
    drive(0, 1, 0, 0, 1, 1, 1, 1); step();
    drive(0, 1, 0, 1, 1, 0, 1, 1); step(); expectOp("R6 read continue", 3, 1);
    drive(0, 1, 0, 1, 1, 1, 1, 1); step(); expectOp("R7 read hold", 5, 2);
    drive(0, 1, 0, 1, 0, 1, 0, 1); step();
    drive(0, 1, 0, 1, 1, 0, 1, 1); step(); expectOp("R6 write continue", 4, 1);
    drive(0, 1, 0, 1, 1, 1, 1, 1); step(); expectOp("R7 write hold", 6, 2);
    drive(1, 1, 0, 1, 0, 1, 1, 1); step(); expectOp("R2 deselect closes burst", 0, 3);
    drive(0, 1, 0, 1, 1, 0, 1, 1); step(); expectOp("R6 continue without burst", 0, 3);
    drive(0, 1, 0, 1, 1, 1, 1, 1); step(); expectOp("R7 hold without burst", 0, 3);
  endtask

  task automatic tDataBus();
    drive(0, 1, 0, 0, 1, 1, 1, 0); step();
    chk("R8 read oeN low drives", dataDrive, 1);
    chk("R8 read no capture", dataCapture, 0);
    drive(0, 1, 0, 1, 1, 0, 1, 1); step();
    chk("R8 read oeN high no drive", dataDrive, 0);
    drive(0, 1, 0, 1, 0, 1, 0, 0); step();
    chk("R8 write no drive", dataDrive, 0);
    chk("R8 write capture", dataCapture, 1);
    drive(1, 1, 0, 1, 0, 1, 1, 0); step();
    chk("R8 deselect no capture", dataCapture, 0);
  endtask

  task automatic tSleepEntry();
    drive(0, 1, 0, 0, 1, 1, 1, 1); step();
    drive(0, 1, 0, 1, 1, 0, 1, 1);
    sleepReq = 1'b1;
    step(); chk("R10 awake after k", sleepState, 0); chk("R10 op after k", opType, 3);
    step(); chk("R10 awake after k+1", sleepState, 0);
    step();
    chk("R10 entering after k+2", sleepState, 1);
    chk("R10 snooze after k+2", opType, 7);
    chk("R11 abort pulse", burstAbort, 1);
    drive(0, 1, 0, 0, 1, 1, 1, 0);
    step();
    chk("R11 abort one cycle", burstAbort, 0);
    chk("R10 strobe ignored", opType, 7);
    chk("R10 no drive in snooze", dataDrive, 0);
    step(); chk("R10 asleep after k+4", sleepState, 2);
    drive(0, 1, 0, 1, 1, 0, 1, 1);
    repeat (3) step();
    chk("R10 stays asleep", sleepState, 2);
  endtask

  task automatic tSleepExit();
    sleepReq = 1'b0;
    step(); chk("R12 asleep after j", sleepState, 2);
    step(); chk("R12 asleep after j+1", sleepState, 2);
    step(); chk("R12 exiting after j+2", sleepState, 3);
    chk("R12 no violation yet", protocolViolation, 0);
    drive(0, 1, 0, 1, 0, 1, 0, 1);
    step();
    chk("R12 violation flagged", protocolViolation, 1);
    chk("R12 strobe ignored", opType, 7);
    drive(0, 1, 0, 1, 1, 0, 1, 1);
    step();
    chk("R12 awake after j+4", sleepState, 0);
    chk("R12 violation one cycle", protocolViolation, 0);
    step(); expectOp("R11 burst closed after wake", 0, 3);
    drive(0, 1, 0, 0, 1, 1, 1, 1);
    step(); expectOp("R3 decode resumes", 1, 0);
  endtask

  initial begin
    tReset();
    tDecode();
    tBurst();
    tDataBus();
    tSleepEntry();
    tSleepExit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule